// File: doc/BRIEF.md
# Memory Protection Region Checker

This block sits between a processor's load/store path and memory and decides, in the same cycle as the access, whether the access may proceed. The 16-bit address space is split into sixteen regions of 4K words each. A protection mask holds one bit per region. A user-mode access is allowed only when the bit for its region is set. A privileged access is always allowed. The device register window at the top of the address space is closed to user code whatever the mask says.

When an access is refused, the block raises a fault pulse for that cycle, which the processor uses to enter its illegal-access handler. It also suppresses the access: no memory write enable goes out, and the read data returned to the core is forced to zero. Only privileged code may load the mask. A user-mode attempt to load it is refused and reported through the same fault pulse. Reset clears the mask, so user code has no access until the supervisor sets the mask up.

Top module: `mem_guard`

## Requirements
- R1: After reset the mask is all zero, so every user-mode access faults until privileged code loads the mask.
- R2: The region of an access is address bits [15:12]. Mask bit i covers i*x1000 through i*x1000+x0FFF. A user access to a region whose bit is set, outside the device window, does not fault.
- R3: A user access to a region whose mask bit is clear faults.
- R4: A privileged access never faults, at any address, including the device window.
- R5: A user access to any address from xFE00 to xFFFF faults even when mask bit 15 is set. A user access to xFDFF with bit 15 set does not fault.
- R6: A mask write made with privMode high stores maskWrData, and the new mask governs accesses from the next cycle on.
- R7: A mask write made with privMode low leaves the mask unchanged and raises accFault in that cycle. Any access presented in the same cycle is also suppressed.
- R8: memWrEn is high exactly in cycles that have a valid store (accWrite=1) and no fault.
- R9: rdDataOut equals rdDataIn in cycles that have a valid load (accWrite=0) and no fault. In all other cycles rdDataOut is zero.
- R10: accFault is combinational, aligned with the strobe of the offending request. It is low in any cycle without accValid or maskWrEn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears the mask |
| accValid | input | 1 | Load/store strobe from the core |
| accWrite | input | 1 | 1 = store, 0 = load |
| accAddr | input | 16 | Access address |
| privMode | input | 1 | Core is in privileged mode |
| maskWrEn | input | 1 | Request to load the protection mask |
| maskWrData | input | 16 | New mask value, one bit per region |
| rdDataIn | input | 16 | Read data from memory |
| memWrEn | output | 1 | Write enable forwarded to memory |
| rdDataOut | output | 16 | Read data returned to the core, zero when suppressed |
| accFault | output | 1 | Illegal-access pulse |

## Verification
The hardest case to reach is a user store that the mask would allow, arriving in the same cycle as a refused user-mode mask write. Only the combination shows whether that cycle's fault also gates the store. The bench drives this overlap on purpose. It also drives it indirectly through a long random phase, in which the reference model predicts the fault, the write enable and the read data each cycle. The device window edge at xFDFF/xFE00 is reached only after privileged code opens region 15, so the bench sets that mask first.

// File: rtl/mg_pkg.sv
package mg_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic maskLoad;  // commit a new mask this edge
    logic wrPass;    // store may reach memory
    logic rdPass;    // load data may reach the core
  } guardStrobes_t;
endpackage

// File: rtl/mg_datapath.sv
module mg_datapath
  import mg_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int REGION_BITS = 4,
  parameter int IO_BASE     = 'hFE00
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             accAddr,
  input  logic [(1<<REGION_BITS)-1:0]   maskWrData,
  input  logic [DATA_W-1:0]             rdDataIn,
  input  guardStrobes_t                 strobes,
  output logic                          regionOpen,
  output logic                          ioHit,
  output logic                          memWrEn,
  output logic [DATA_W-1:0]             rdDataOut
);
  localparam int NUM_REGIONS = 1 << REGION_BITS;
  localparam logic [ADDR_W-1:0] IO_LO = ADDR_W'(IO_BASE);

  logic [NUM_REGIONS-1:0] protMask;
  logic [NUM_REGIONS-1:0] regionHit;
  logic [REGION_BITS-1:0] regionIdx;

  always_ff @(posedge clk) begin
    if (!rst_n)
      protMask <= '0;
    else if (strobes.maskLoad)
      protMask <= maskWrData;
  end

  assign regionIdx = accAddr[ADDR_W-1 -: REGION_BITS];

  // one-hot region decode
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    assign regionHit[g] = (regionIdx == REGION_BITS'(g));
  end

  assign regionOpen = |(regionHit & protMask);
  assign ioHit      = (accAddr >= IO_LO);

  assign memWrEn   = strobes.wrPass;
  assign rdDataOut = strobes.rdPass ? rdDataIn : '0;
endmodule

// File: rtl/mg_control.sv
module mg_control
  import mg_pkg::*;
(
  input  logic          accValid,
  input  logic          accWrite,
  input  logic          privMode,
  input  logic          maskWrEn,
  input  logic          regionOpen,
  input  logic          ioHit,
  output guardStrobes_t strobes,
  output logic          accFault
);
  logic accDeny;
  logic cfgDeny;

  always_comb begin
    accDeny  = accValid && !privMode && (!regionOpen || ioHit);
    cfgDeny  = maskWrEn && !privMode;
    accFault = accDeny || cfgDeny;
    strobes.maskLoad = maskWrEn && privMode;
    strobes.wrPass   = accValid && accWrite  && !accFault;
    strobes.rdPass   = accValid && !accWrite && !accFault;
  end
endmodule

// File: rtl/mem_guard.sv
module mem_guard
  import mg_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int REGION_BITS = 4,
  parameter int IO_BASE     = 'hFE00
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        accValid,
  input  logic                        accWrite,
  input  logic [ADDR_W-1:0]           accAddr,
  input  logic                        privMode,
  input  logic                        maskWrEn,
  input  logic [(1<<REGION_BITS)-1:0] maskWrData,
  input  logic [DATA_W-1:0]           rdDataIn,
  output logic                        memWrEn,
  output logic [DATA_W-1:0]           rdDataOut,
  output logic                        accFault
);
  guardStrobes_t strobes;
  logic          regionOpen;
  logic          ioHit;

  mg_control u_ctrl (
    .accValid  (accValid),
    .accWrite  (accWrite),
    .privMode  (privMode),
    .maskWrEn  (maskWrEn),
    .regionOpen(regionOpen),
    .ioHit     (ioHit),
    .strobes   (strobes),
    .accFault  (accFault)
  );

  mg_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .REGION_BITS(REGION_BITS), .IO_BASE(IO_BASE)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accAddr   (accAddr),
    .maskWrData(maskWrData),
    .rdDataIn  (rdDataIn),
    .strobes   (strobes),
    .regionOpen(regionOpen),
    .ioHit     (ioHit),
    .memWrEn   (memWrEn),
    .rdDataOut (rdDataOut)
  );
endmodule

// File: rtl/mg_guard_chk.sv
module mg_guard_chk #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int REGION_BITS = 4,
  parameter int IO_BASE     = 'hFE00
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        accValid,
  input logic                        accWrite,
  input logic [ADDR_W-1:0]           accAddr,
  input logic                        privMode,
  input logic                        maskWrEn,
  input logic [(1<<REGION_BITS)-1:0] maskWrData,
  input logic [DATA_W-1:0]           rdDataIn,
  input logic                        memWrEn,
  input logic [DATA_W-1:0]           rdDataOut,
  input logic                        accFault
);
  localparam logic [ADDR_W-1:0] IO_LO = ADDR_W'(IO_BASE);

  // R4
  priv_never_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    privMode |-> !accFault);

  // R5
  io_window_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accValid && !privMode && accAddr >= IO_LO) |-> accFault);

  // R7
  user_cfg_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (maskWrEn && !privMode) |-> accFault);

  // R8
  store_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memWrEn |-> (accValid && accWrite && !accFault));

  // R9
  load_zeroed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accFault || !accValid || accWrite) |-> (rdDataOut == '0 || rdDataIn == '0) && rdDataOut == '0);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!accValid && !maskWrEn) |-> !accFault);

  // R9
  load_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accValid && !accWrite && !accFault) |-> rdDataOut == rdDataIn);
endmodule

bind mem_guard mg_guard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .REGION_BITS(REGION_BITS), .IO_BASE(IO_BASE)
) u_chk (.*);

// File: tb/sim_mem_guard.sv
module sim_mem_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        accValid = 1'b0;
  logic        accWrite = 1'b0;
  logic [15:0] accAddr = '0;
  logic        privMode = 1'b0;
  logic        maskWrEn = 1'b0;
  logic [15:0] maskWrData = '0;
  logic [15:0] rdDataIn = '0;
  logic        memWrEn;
  logic [15:0] rdDataOut;
  logic        accFault;

  int          errors = 0;
  int          checks = 0;
  logic [15:0] refMask = '0;

  always #4 clk = ~clk;

  mem_guard u0 (.*);

  task automatic check1(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // drive at negedge, compare mid-low-phase, then advance model at posedge
  task automatic step(input logic v, input logic wr, input logic [15:0] a,
                      input logic pm, input logic mwe, input logic [15:0] md,
                      input logic [15:0] rin, input string tag);
    logic accBad, wrBad, f, expWr;
    logic [15:0] expRd;
    @(negedge clk);
    accValid = v; accWrite = wr; accAddr = a; privMode = pm;
    maskWrEn = mwe; maskWrData = md; rdDataIn = rin;
    #2;
    accBad = v && !pm && (!refMask[a[15:12]] || a >= 16'hFE00);
    wrBad  = mwe && !pm;
    f      = accBad || wrBad;
    expWr  = v && wr && !f;
    expRd  = (v && !wr && !f) ? rin : 16'h0;
    check1(tag, "accFault", int'(accFault), int'(f));
    check1(tag, "memWrEn", int'(memWrEn), int'(expWr));
    check1(tag, "rdDataOut", int'(rdDataOut), int'(expRd));
    @(posedge clk);
    if (mwe && pm) refMask = md;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R10 reset state: idle outputs
    check1("R10", "reset accFault", int'(accFault), 0);
    check1("R10", "reset memWrEn", int'(memWrEn), 0);
    check1("R10", "reset rdDataOut", int'(rdDataOut), 0);
    @(negedge clk);
    rst_n = 1'b1;

    step(1, 0, 16'h1234, 0, 0, 0, 16'hBEEF, "R1");
    step(1, 1, 16'hF000, 0, 0, 0, 16'h0000, "R1");
    step(1, 0, 16'h1234, 1, 0, 0, 16'hA5A5, "R4");
    step(1, 0, 16'h4000, 0, 1, 16'h0070, 16'h1111, "R7");
    step(1, 0, 16'h4000, 0, 0, 0, 16'h2222, "R7");
    step(0, 0, 16'h0000, 1, 1, 16'h0070, 16'h0, "R6");
    step(1, 0, 16'h4000, 0, 0, 0, 16'h3C3C, "R6");
    step(1, 1, 16'h6FFF, 0, 0, 0, 16'h0, "R2");
    step(1, 0, 16'h5ABC, 0, 0, 0, 16'h7E7E, "R2");
    step(1, 0, 16'h7000, 0, 0, 0, 16'h9999, "R3");
    step(1, 0, 16'h7000, 0, 0, 0, 16'h9999, "R9");
    step(1, 1, 16'h3FFF, 0, 0, 0, 16'h0, "R8");
    step(1, 1, 16'h4001, 0, 0, 0, 16'h0, "R8");
    step(0, 1, 16'h4001, 0, 0, 0, 16'hFFFF, "R10");
    step(0, 0, 16'h0, 1, 1, 16'h8000, 16'h0, "R6");
    step(1, 0, 16'hFDFF, 0, 0, 0, 16'h5555, "R5");
    step(1, 0, 16'hFE00, 0, 0, 0, 16'h5555, "R5");
    step(1, 1, 16'hFFFF, 0, 0, 0, 16'h0, "R5");
    step(1, 1, 16'hFE06, 1, 0, 0, 16'h0, "R4");
    step(1, 0, 16'h4000, 0, 0, 0, 16'h1234, "R3");
    step(1, 1, 16'hF100, 0, 1, 16'hFFFF, 16'h0, "R7");
    step(1, 0, 16'h0100, 0, 0, 0, 16'h4321, "R7");

    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0], r[1], 16'($urandom), r[2] & r[3], (r[7:4] == 4'h0),
           16'($urandom), 16'($urandom), "R10");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule